// File: doc/BRIEF.md
# Stage-1 Translation Table Walker

This block turns an input virtual address into an output address by walking a multi-level table of 64-bit descriptors held in memory. A caller presents one request at a time: the address, whether the access is a write, the table base of the already chosen region, the region size field (TSZ), the granule (4 KB, 16 KB or 64 KB), a flag that suppresses access-flag faults and a flag that disables the hierarchical permission bits of table descriptors. The walker derives its starting level from TSZ and the granule. It fetches one descriptor per level over a plain request/response memory port and follows table descriptors downward until a page or block descriptor ends the walk.

On success it returns the output base address, the input address aligned to the mapped region, the region mask, the permissions, the final level and the granule. On any fault it returns a fault code with stage 1 and no permissions. A bus error also reports the address of the descriptor that could not be read. Caching of results and choosing between table regions belong to the caller.

Top module: `s1_table_walker`

## Requirements
- R1: With g = log2(granule) (granule code 0 = 4 KB, 1 = 16 KB, 2 = 64 KB), stride s = g − 3 and input size n = 64 − TSZ, the first descriptor is read at level 4 − (n − 4)/s (integer division), and the walk never goes past level 3.
- R2: At level L the index is the address field starting at bit g + (3 − L)·s, min(s, n − that bit) bits wide. Each descriptor is read from the 48-bit table base, with its low (index width + 3) bits cleared, plus index·8.
- R3: A read response with the error flag set ends the walk with fault code 4 (external abort), and the failing descriptor's address is returned on `done_faddr`.
- R4: A descriptor with bit 0 clear, a level-3 descriptor with bit 1 clear, or a level-0 descriptor with bit 1 clear ends the walk with fault code 1 (translation).
- R5: A table descriptor (bit 0 and bit 1 set, level below 3) whose bit 62 is set denies writes below it. A write then gives fault code 3 (permission) unless the hierarchical-disable input is high, in which case the walk continues.
- R6: After a permitted table descriptor, the next level's base is the descriptor's bits [47:g] with the low g bits zero.
- R7: A page descriptor (level 3, bits 1:0 = 11) or a block descriptor (level 1 or 2, bits 1:0 = 01) ends the walk. Let k be the level's shift. The result is: output address = descriptor bits [47:k] with the low k bits zero; mask = 2^k − 1; aligned input = address with the mask bits cleared; the final level; the granule code; stage 0; fault code 0.
- R8: A leaf descriptor with bit 10 (access flag) clear gives fault code 2 (access) when the access-fault-suppress input is low. This takes precedence over a permission fault.
- R9: A write to a leaf whose bit 7 is set gives fault code 3. Permissions returned on success are 01 (read only) when bit 7 is set, else 11 (read and write); bit 0 = read, bit 1 = write.
- R10: Every fault returns stage 1 and permission 00.
- R11: `req_ready` is high only when the walker is idle. A request presented while it is busy is ignored.
- R12: Each level issues exactly one single-cycle memory request, and no second request goes out before the response arrives. A walk reads exactly the levels from the start level to the level where it stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 64 | Address to translate |
| req_write | input | 1 | Access is a write |
| req_tbase | input | 48 | Table base of the selected region |
| req_tsz | input | 6 | Region size field (input size = 64 − value) |
| req_gran | input | 2 | Granule code: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB |
| req_affd | input | 1 | Suppress access-flag faults |
| req_hd | input | 1 | Ignore table-level permission bits |
| mem_req_valid | output | 1 | Descriptor read request (one cycle) |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Descriptor, little-endian 64-bit word |
| mem_rsp_err | input | 1 | Read failed on the bus |
| done_valid | output | 1 | Result valid (one cycle) |
| done_fault | output | 3 | 0 none, 1 translation, 2 access, 3 permission, 4 external abort |
| done_stage | output | 2 | 1 on a fault, 0 on success |
| done_oa | output | 48 | Output base address |
| done_ia | output | 64 | Input address aligned to the mapping |
| done_mask | output | 64 | Offset mask of the mapping |
| done_perm | output | 2 | bit 0 read, bit 1 write |
| done_level | output | 2 | Level where the walk ended |
| done_gran | output | 2 | Granule code of the walk |
| done_faddr | output | 48 | Descriptor address of a failed read |

## Verification
The bench covers start levels 0 to 3 across all three granules. A start-level or index-width error shows up as a descriptor read at an address the table model does not hold, or as a wrong read count. It forces the fault-precedence cases: a cleared access flag together with a read-only write must give access rather than permission, and table bit 62 must stop a write only while hierarchical-disable is low. A walker that masked with the granule instead of the level shift would return block results with the wrong mask or alignment. The bench also checks reserved encodings at level 3 and level 0, bus errors at an inner level with the faulting address, and requests raised while the walker is busy, which must be dropped.

// File: rtl/ptw_pkg.sv
// Shared types for the stage-1 table walker.
// Assumes: granule codes 0/1/2 select 4K/16K/64K; code 3 behaves as 4K.
package ptw_pkg;
    localparam int IDX_W = 13;   // widest per-level index (64K granule)

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_XLATE  = 3'd1,
        FLT_ACCESS = 3'd2,
        FLT_PERM   = 3'd3,
        FLT_EXTABT = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        D_BAD   = 2'd0,
        D_TABLE = 2'd1,
        D_LEAF  = 2'd2
    } dkind_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_FETCH  = 3'd1,
        S_WAIT   = 3'd2,
        S_DECODE = 3'd3,
        S_DONE   = 3'd4
    } wstate_e;

    // log2 of the granule size for a granule code
    function automatic logic [4:0] gran_log2(input logic [1:0] code);
        case (code)
            2'd1:    gran_log2 = 5'd14;
            2'd2:    gran_log2 = 5'd16;
            default: gran_log2 = 5'd12;
        endcase
    endfunction
endpackage

// File: rtl/ptw_geom.sv
// Level geometry: start level, per-level shift, table index and base mask.
// Purely combinational. Assumes TSZ gives a start level in 0..3.
module ptw_geom
    import ptw_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 48
) (
    input  logic [1:0]       gran_i,
    input  logic [5:0]       tsz_i,
    input  logic [1:0]       lvl_i,
    input  logic [VA_W-1:0]  va_i,
    output logic [4:0]       gsz_o,
    output logic [1:0]       start_o,
    output logic [7:0]       shift_o,
    output logic [IDX_W-1:0] index_o,
    output logic [PA_W-1:0]  lowmask_o
);
    logic [7:0] gsz8, strd, isz, quot, sh, room, ib;
    logic [IDX_W-1:0] imask;

    // derive stride, start level, shift and index width for lvl_i
    always_comb begin
        gsz8  = {3'b000, gran_log2(gran_i)};
        strd  = gsz8 - 8'd3;
        isz   = 8'd64 - {2'b00, tsz_i};
        quot  = (isz - 8'd4) / strd;
        sh    = gsz8 + (8'd3 - {6'b0, lvl_i}) * strd;
        room  = isz - sh;
        ib    = (room < strd) ? room : strd;
        imask = (IDX_W'(1) << ib) - IDX_W'(1);
    end

    assign gsz_o     = gran_log2(gran_i);
    assign start_o   = 2'(8'd4 - quot);
    assign shift_o   = sh;
    assign index_o   = IDX_W'(va_i >> sh) & imask;
    assign lowmask_o = (PA_W'(1) << (ib + 8'd3)) - PA_W'(1);
endmodule

// File: rtl/ptw_desc_chk.sv
// Descriptor classifier: kind (bad/table/leaf) and the fault it raises.
// Combinational. Access-flag fault is tested before leaf permission.
module ptw_desc_chk
    import ptw_pkg::*;
(
    input  logic [63:0] desc_i,
    input  logic [1:0]  lvl_i,
    input  logic        write_i,
    input  logic        affd_i,
    input  logic        hd_i,
    output dkind_e      kind_o,
    output fault_e      fault_o
);
    logic chk_unused;
    assign chk_unused = ^{desc_i[63], desc_i[61:11], desc_i[9:8], desc_i[6:2]};

    // classify the descriptor by valid bit, type bit and level
    always_comb begin
        if (!desc_i[0])
            kind_o = D_BAD;
        else if (lvl_i == 2'd3)
            kind_o = desc_i[1] ? D_LEAF : D_BAD;
        else if (desc_i[1])
            kind_o = D_TABLE;
        else
            kind_o = (lvl_i == 2'd0) ? D_BAD : D_LEAF;
    end

    // pick the fault in precedence order for that kind
    always_comb begin
        fault_o = FLT_NONE;
        case (kind_o)
            D_BAD:   fault_o = FLT_XLATE;
            D_TABLE: if (write_i && desc_i[62] && !hd_i) fault_o = FLT_PERM;
            D_LEAF: begin
                if (!desc_i[10] && !affd_i)   fault_o = FLT_ACCESS;
                else if (write_i && desc_i[7]) fault_o = FLT_PERM;
            end
            default: fault_o = FLT_XLATE;
        endcase
    end
endmodule

// File: rtl/s1_table_walker.sv
// Stage-1 table walker top: IDLE -> FETCH -> WAIT -> DECODE -> (FETCH | DONE).
// One descriptor read per level; result held until the next walk.
// Assumes the memory answers every request exactly once.
module s1_table_walker
    import ptw_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    input  logic            req_write,
    input  logic [PA_W-1:0] req_tbase,
    input  logic [5:0]      req_tsz,
    input  logic [1:0]      req_gran,
    input  logic            req_affd,
    input  logic            req_hd,
    output logic            mem_req_valid,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            done_valid,
    output logic [2:0]      done_fault,
    output logic [1:0]      done_stage,
    output logic [PA_W-1:0] done_oa,
    output logic [VA_W-1:0] done_ia,
    output logic [VA_W-1:0] done_mask,
    output logic [1:0]      done_perm,
    output logic [1:0]      done_level,
    output logic [1:0]      done_gran,
    output logic [PA_W-1:0] done_faddr
);
    wstate_e         st;
    logic [VA_W-1:0] va_q;
    logic            wr_q, affd_q, hd_q, err_q;
    logic [1:0]      gran_q, lvl_q;
    logic [5:0]      tsz_q;
    logic [PA_W-1:0] base_q, daddr_q;
    logic [63:0]     desc_q;

    fault_e          r_fault;
    logic [1:0]      r_stage, r_perm, r_level, r_gran;
    logic [PA_W-1:0] r_oa, r_faddr;
    logic [VA_W-1:0] r_ia, r_mask;

    logic [1:0]       g_gran;
    logic [5:0]       g_tsz;
    logic [4:0]       g_gsz;
    logic [1:0]       g_start;
    logic [7:0]       g_shift;
    logic [IDX_W-1:0] g_index;
    logic [PA_W-1:0]  g_lowmask, fetch_addr, gmask;
    logic [VA_W-1:0]  lvl_mask;
    dkind_e           c_kind;
    fault_e           c_fault;

    // geometry follows the request while idle, the latched walk otherwise
    assign g_gran = (st == S_IDLE) ? req_gran : gran_q;
    assign g_tsz  = (st == S_IDLE) ? req_tsz  : tsz_q;

    ptw_geom #(.VA_W(VA_W), .PA_W(PA_W)) u_geom (
        .gran_i(g_gran), .tsz_i(g_tsz), .lvl_i(lvl_q), .va_i(va_q),
        .gsz_o(g_gsz), .start_o(g_start), .shift_o(g_shift),
        .index_o(g_index), .lowmask_o(g_lowmask)
    );

    ptw_desc_chk u_chk (
        .desc_i(desc_q), .lvl_i(lvl_q), .write_i(wr_q), .affd_i(affd_q),
        .hd_i(hd_q), .kind_o(c_kind), .fault_o(c_fault)
    );

    assign fetch_addr = (base_q & ~g_lowmask) + PA_W'({g_index, 3'b000});
    assign gmask      = (PA_W'(1) << g_gsz) - PA_W'(1);
    assign lvl_mask   = (VA_W'(1) << g_shift) - VA_W'(1);

    // walk sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            affd_q  <= 1'b0;
            hd_q    <= 1'b0;
            err_q   <= 1'b0;
            gran_q  <= '0;
            lvl_q   <= '0;
            tsz_q   <= '0;
            base_q  <= '0;
            daddr_q <= '0;
            desc_q  <= '0;
            r_fault <= FLT_NONE;
            r_stage <= '0;
            r_perm  <= '0;
            r_level <= '0;
            r_gran  <= '0;
            r_oa    <= '0;
            r_faddr <= '0;
            r_ia    <= '0;
            r_mask  <= '0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    wr_q   <= req_write;
                    affd_q <= req_affd;
                    hd_q   <= req_hd;
                    gran_q <= req_gran;
                    tsz_q  <= req_tsz;
                    base_q <= req_tbase;
                    lvl_q  <= g_start;
                    st     <= S_FETCH;
                end
                S_FETCH: begin
                    daddr_q <= fetch_addr;
                    st      <= S_WAIT;
                end
                S_WAIT: if (mem_rsp_valid) begin
                    desc_q <= mem_rsp_data;
                    err_q  <= mem_rsp_err;
                    st     <= S_DECODE;
                end
                S_DECODE: begin
                    r_gran  <= gran_q;
                    r_level <= lvl_q;
                    if (err_q || c_fault != FLT_NONE) begin
                        r_fault <= err_q ? FLT_EXTABT : c_fault;
                        r_faddr <= daddr_q;
                        r_stage <= 2'd1;
                        r_perm  <= 2'b00;
                        r_oa    <= '0;
                        r_ia    <= '0;
                        r_mask  <= '0;
                        st      <= S_DONE;
                    end else if (c_kind == D_TABLE) begin
                        base_q <= desc_q[PA_W-1:0] & ~gmask;
                        lvl_q  <= lvl_q + 2'd1;
                        st     <= S_FETCH;
                    end else begin
                        r_fault <= FLT_NONE;
                        r_faddr <= '0;
                        r_stage <= 2'd0;
                        r_perm  <= desc_q[7] ? 2'b01 : 2'b11;
                        r_oa    <= desc_q[PA_W-1:0] & ~lvl_mask[PA_W-1:0];
                        r_ia    <= va_q & ~lvl_mask;
                        r_mask  <= lvl_mask;
                        st      <= S_DONE;
                    end
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready     = (st == S_IDLE);
    assign mem_req_valid = (st == S_FETCH);
    assign mem_req_addr  = fetch_addr;
    assign done_valid    = (st == S_DONE);
    assign done_fault    = r_fault;
    assign done_stage    = r_stage;
    assign done_oa       = r_oa;
    assign done_ia       = r_ia;
    assign done_mask     = r_mask;
    assign done_perm     = r_perm;
    assign done_level    = r_level;
    assign done_gran     = r_gran;
    assign done_faddr    = r_faddr;

    // R12
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault != 3'd0) |-> (done_perm == 2'b00 && done_stage == 2'd1));
    // R7
    leaf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 3'd0) |-> ((done_ia & done_mask) == '0 && done_stage == 2'd0));
    // R3
    abort_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 3'd4) |-> (done_faddr[2:0] == 3'b000));
endmodule

// File: tb/sim_s1_table_walker.sv
module sim_s1_table_walker;
    localparam int F_ERR = 1, F_INV = 2, F_RSV = 4, F_AF0 = 8, F_RO = 16, F_APT = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, req_valid, req_ready, req_write, req_affd, req_hd;
    logic [63:0] req_va;
    logic [47:0] req_tbase;
    logic [5:0]  req_tsz;
    logic [1:0]  req_gran;
    logic        mem_req_valid, mem_rsp_valid, mem_rsp_err;
    logic [47:0] mem_req_addr;
    logic [63:0] mem_rsp_data;
    logic        done_valid;
    logic [2:0]  done_fault;
    logic [1:0]  done_stage, done_perm, done_level, done_gran;
    logic [47:0] done_oa, done_faddr;
    logic [63:0] done_ia, done_mask;

    s1_table_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .req_tbase(req_tbase),
        .req_tsz(req_tsz), .req_gran(req_gran), .req_affd(req_affd), .req_hd(req_hd),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done_valid(done_valid), .done_fault(done_fault), .done_stage(done_stage),
        .done_oa(done_oa), .done_ia(done_ia), .done_mask(done_mask), .done_perm(done_perm),
        .done_level(done_level), .done_gran(done_gran), .done_faddr(done_faddr)
    );

    int n_chk = 0, n_err = 0, n_reads = 0, bad_addr = 0;
    logic [47:0] m_addr [4];
    logic [63:0] m_data [4];
    bit          m_err  [4];
    bit          m_use  [4];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // memory model: answers each read 1..3 cycles later from the table arrays
    initial begin
        logic [47:0] a;
        bit hit;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                a = mem_req_addr;
                hit = 1'b0;
                n_reads++;
                repeat (1 + $urandom_range(0, 2)) @(negedge clk);
                mem_rsp_data = 64'h0;
                mem_rsp_err  = 1'b0;
                for (int j = 0; j < 4; j++)
                    if (m_use[j] && m_addr[j] == a && !hit) begin
                        hit = 1'b1;
                        mem_rsp_data = m_err[j] ? 64'hDEAD_BEEF_0000_0003 : m_data[j];
                        mem_rsp_err  = m_err[j];
                    end
                if (!hit) bad_addr++;
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    function automatic logic [47:0] rnd48();
        return 48'({$urandom(), $urandom()});
    endfunction

    // build tables for one walk, compute the expected result, run and compare
    task automatic do_walk(input int g, input int tsz, input logic [63:0] va,
                           input logic [47:0] base, input bit w, input bit affd,
                           input bit hd, input int leaf_in, input int fl, input string tag);
        int gsz = 12 + 2 * g;
        int strd = gsz - 3;
        int isz = 64 - tsz;
        int start = 4 - (isz - 4) / strd;
        int leaf = (leaf_in < start) ? start : leaf_in;
        int sh = 0, ib = 0, leaf_sh = 0, exp_reads;
        int waitc = 0;
        logic [47:0] b = base, nxt, oa = '0, leaf_oa = '0;
        logic [63:0] idx, d, emask, eia;
        logic [2:0]  ef;
        logic [47:0] efa = '0;
        for (int j = 0; j < 4; j++) m_use[j] = 1'b0;
        for (int l = start; l <= leaf; l++) begin
            sh = gsz + (3 - l) * strd;
            ib = (isz - sh < strd) ? isz - sh : strd;
            idx = (va >> sh) & ((64'd1 << ib) - 64'd1);
            b = b & ~((48'd1 << (ib + 3)) - 48'd1);
            m_use[l]  = 1'b1;
            m_addr[l] = b + 48'(idx * 8);
            m_err[l]  = (l == leaf) && ((fl & F_ERR) != 0);
            if (l < leaf) begin
                nxt = rnd48() & ~((48'd1 << gsz) - 48'd1);
                d = {16'h0, nxt} | 64'd3;
                if (l == start && (fl & F_APT) != 0) d[62] = 1'b1;
                m_data[l] = d;
                b = nxt;
            end else begin
                oa = rnd48() & ~((48'd1 << sh) - 48'd1);
                d = {16'h0, oa} | ((l == 3) ? 64'd3 : 64'd1);
                if ((fl & F_INV) != 0) d[0] = 1'b0;
                if ((fl & F_RSV) != 0 && l == 3) d[1] = 1'b0;
                d[10] = ((fl & F_AF0) == 0);
                d[7]  = ((fl & F_RO) != 0);
                m_data[l] = d;
                leaf_oa = oa;
                leaf_sh = sh;
            end
        end
        // reference outcome in requirement precedence order
        exp_reads = leaf - start + 1;
        if ((fl & F_APT) != 0 && start < leaf && w && !hd) begin
            ef = 3'd3; exp_reads = 1;
        end else if ((fl & F_ERR) != 0) begin
            ef = 3'd4; efa = m_addr[leaf];
        end else if ((fl & F_INV) != 0 || ((fl & F_RSV) != 0 && leaf == 3) || leaf == 0)
            ef = 3'd1;
        else if ((fl & F_AF0) != 0 && !affd)
            ef = 3'd2;
        else if ((fl & F_RO) != 0 && w)
            ef = 3'd3;
        else
            ef = 3'd0;
        emask = (64'd1 << leaf_sh) - 64'd1;
        eia = va & ~emask;

        n_reads = 0; bad_addr = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", {tag, " ready before request"}, 64'(req_ready), 64'd1);
        req_va = va; req_write = w; req_tbase = base; req_tsz = 6'(tsz);
        req_gran = 2'(g); req_affd = affd; req_hd = hd; req_valid = 1'b1;
        @(negedge clk);
        // busy: a new request must be refused and have no effect
        req_va = ~va; req_write = ~w; req_valid = 1'b1;
        check(req_ready == 1'b0, "R11", {tag, " ready while busy"}, 64'(req_ready), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done_valid && waitc < 80) begin
            @(negedge clk);
            waitc++;
        end
        check(done_valid == 1'b1, "R12", {tag, " walk completes"}, 64'(done_valid), 64'd1);
        check(bad_addr == 0, "R2 R6", {tag, " descriptor addresses"}, 64'(bad_addr), 64'd0);
        check(n_reads == exp_reads, "R12", {tag, " read count"}, 64'(n_reads), 64'(exp_reads));
        check(done_fault == ef, {"R1 ", tag}, "fault code", 64'(done_fault), 64'(ef));
        if (ef == 3'd0) begin
            check(done_oa == leaf_oa, "R7", {tag, " output address"}, 64'(done_oa), 64'(leaf_oa));
            check(done_ia == eia, "R7", {tag, " aligned input"}, done_ia, eia);
            check(done_mask == emask, "R7", {tag, " mask"}, done_mask, emask);
            check(done_level == 2'(leaf), "R7", {tag, " level"}, 64'(done_level), 64'(leaf));
            check(done_gran == 2'(g), "R7", {tag, " granule"}, 64'(done_gran), 64'(g));
            check(done_stage == 2'd0, "R7", {tag, " stage"}, 64'(done_stage), 64'd0);
            check(done_perm == (((fl & F_RO) != 0) ? 2'b01 : 2'b11), "R9",
                  {tag, " permission"}, 64'(done_perm), ((fl & F_RO) != 0) ? 64'd1 : 64'd3);
        end else begin
            check(done_perm == 2'b00, "R10", {tag, " fault perm"}, 64'(done_perm), 64'd0);
            check(done_stage == 2'd1, "R10", {tag, " fault stage"}, 64'(done_stage), 64'd1);
            if (ef == 3'd4)
                check(done_faddr == efa, "R3", {tag, " abort address"}, 64'(done_faddr), 64'(efa));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_tbase = '0;
        req_tsz = '0; req_gran = '0; req_affd = 1'b0; req_hd = 1'b0;
        for (int j = 0; j < 4; j++) m_use[j] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "reset ready", 64'(req_ready), 64'd1);
        check(mem_req_valid == 1'b0, "R12", "reset no read", 64'(mem_req_valid), 64'd0);
        check(done_valid == 1'b0, "R10", "reset no result", 64'(done_valid), 64'd0);

        do_walk(0, 16, 64'h0000_7ABC_DEF1_2345, rnd48(), 0, 0, 0, 3, 0, "R1 4K L0-L3 page");
        do_walk(0, 25, 64'h0000_0045_6789_ABCD, rnd48(), 1, 0, 0, 1, 0, "R7 4K L1 block");
        do_walk(2, 22, 64'h0000_0321_FEDC_BA98, rnd48(), 0, 0, 0, 3, 0, "R1 64K start L2");
        do_walk(1, 20, 64'h0000_0ABC_1234_5678, rnd48(), 0, 0, 0, 2, F_ERR, "R3 inner bus error");
        do_walk(0, 16, 64'h0000_1111_2222_3333, rnd48(), 1, 0, 0, 3, F_AF0 | F_RO, "R8 AF before perm");
        do_walk(0, 16, 64'h0000_1111_2222_3333, rnd48(), 0, 1, 0, 3, F_AF0, "R8 AF suppressed");
        do_walk(0, 16, 64'h0000_4444_5555_6666, rnd48(), 1, 0, 0, 3, F_APT, "R5 table write deny");
        do_walk(0, 16, 64'h0000_4444_5555_6666, rnd48(), 1, 0, 1, 3, F_APT, "R5 hier disabled");
        do_walk(1, 30, 64'h0000_0001_2345_6789, rnd48(), 0, 0, 0, 3, F_INV, "R4 invalid");
        do_walk(0, 16, 64'h0000_0F0F_0F0F_0F0F, rnd48(), 0, 0, 0, 3, F_RSV, "R4 L3 reserved");
        do_walk(0, 16, 64'h0000_0F0F_0F0F_0F0F, rnd48(), 0, 0, 0, 0, 0, "R4 L0 block");
        do_walk(2, 39, 64'h0000_0000_0123_4567, rnd48(), 0, 0, 0, 3, F_RO, "R9 read-only read");
        do_walk(2, 39, 64'h0000_0000_0123_4567, rnd48(), 1, 0, 0, 3, F_RO, "R9 read-only write");

        for (int i = 0; i < 300; i++) begin
            int g = $urandom_range(0, 2);
            int tsz = $urandom_range(16, 39);
            int r = $urandom_range(0, 9);
            int fl = (r == 0) ? F_ERR : (r == 1) ? F_INV : (r == 2) ? F_RSV :
                     (r == 3) ? F_AF0 : (r == 4) ? F_RO : (r == 5) ? F_APT :
                     (r == 6) ? (F_AF0 | F_RO) : 0;
            logic [63:0] va = {$urandom(), $urandom()};
            do_walk(g, tsz, va, rnd48(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), $urandom_range(0, 3), fl, "R7 random");
        end
        finish_run();
    end
endmodule